// File: doc/BRIEF.md
# Two-Wire Trimmer Register Slave

This block is a two-wire serial slave that sits in front of a small bank of 8-bit trimmer registers. The registers are meant to be nonvolatile. Each register gives a 7-bit wiper position and a high-impedance flag to the analog section. The serial clock and data lines are resynchronized to the system clock. The block detects start, stop and repeated-start conditions, compares the incoming device address with strap pins, and acknowledges bytes by pulling the data line low through a drive-low enable.

A write has three parts: the device address with the direction bit low, a register address, and one data byte. The new value is stored only when the master sends a stop. Storing it starts an internally timed commit window. During that window the slave stays off the bus, so a master finds out the commit is done by polling for an acknowledge. A read begins with a dummy write that loads the register address. A repeated start then follows, the address is sent with the direction bit high, and the slave shifts out one byte.

Top module: `trim_serial_slave`

## Requirements
- R1: The slave answers only to the device address formed from the fixed upper bits 101000 and the strap pin as the least significant bit (write byte A2h, read byte A3h with the strap at 1). The address is received MSB first. On a mismatch the slave does not acknowledge and ignores the bus until the next start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start anywhere, including the middle of a transfer, restarts address reception.
- R3: The slave pulls SDA low through the whole ninth SCL pulse after a matching address byte, a register address byte and a write data byte. It sets this drive only while SCL is low.
- R4: After reset every register holds 7Fh, so each position output reads 7Fh and each high-impedance flag reads 0. The busy output is low and SDA is released.
- R5: A write to register address F8h+i changes register i only when the stop arrives. If a repeated start comes before the stop, the data is dropped.
- R6: Bit 7 of a register drives its high-impedance flag, and bits 6:0 drive its position output. Writing 00h gives position 0 with the flag clear. Writing 80h sets the flag.
- R7: After each commit, busy is high for exactly WR_CYCLES system clocks. During that time the slave does not acknowledge its own address.
- R8: A random read returns the stored byte MSB first, one bit per SCL pulse. SDA is released after the eighth bit so the master can send its NACK.
- R9: A write to a register address outside F8h..F8h+N_REG-1 is acknowledged, but no register changes. A read of such an address returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| strap_i | input | STRAP_W | Address strap pins, the low bits of the device address |
| sda_pull_o | output | 1 | Drive-low enable for the open-drain data line |
| busy_o | output | 1 | High while the commit window runs |
| pos_o | output | N_REG*7 | Wiper positions; register i sits at bits 7i+6:7i |
| hiz_o | output | N_REG | High-impedance flag of each register |

## Verification
The hardest state to reach is a write that is fully acknowledged but is cut off by a repeated start instead of a stop. Without the stop the data must not be stored. The bench reaches it by sending the address, register and data bytes and then issuing a start. It checks that the register output is unchanged and that busy never rises. A second hard case is an address arriving during the commit window. The bench sends its address straight after a stop and confirms that no acknowledge comes back. It also confirms that the busy pulse lasts exactly the configured number of clocks.

// File: rtl/trim_pkg.sv
// Shared types for the two-wire trimmer slave.
package trim_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DAT,
        ST_DAT_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } link_state_t;
endpackage

// File: rtl/tw_sync.sv
// Multi-bit two-stage synchronizer with one extra delayed copy for edge detection.
// Assumes the lines idle high, so every stage resets to 1 and no false edge appears after reset.
module tw_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] now_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q, sync_q, old_q;

    // Resynchronize the raw lines and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            old_q  <= '1;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            old_q  <= sync_q;
        end
    end

    assign now_o  = sync_q;
    assign prev_o = old_q;
endmodule

// File: rtl/tw_link.sv
// Two-wire protocol engine: detects start and stop, receives bytes, matches the
// device address, drives acknowledges and read data, and asks for a commit at stop.
// Assumes the SCL/SDA samples come already synchronized. It stays off the bus while busy_i is high.
module tw_link
    import trim_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = 7'h50,
    parameter int         STRAP_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_now,
    input  logic               scl_prev,
    input  logic               sda_now,
    input  logic               sda_prev,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic [7:0]         rd_data_i,
    output logic               sda_low_o,
    output logic               commit_o,
    output logic [7:0]         ptr_o,
    output logic [7:0]         wdata_o
);
    localparam logic [6:0] HI_MASK = 7'h7F << STRAP_W;

    link_state_t state;
    logic [7:0]  shreg, txsh;
    logic [3:0]  cnt;
    logic        pend, rd_mode;
    logic        scl_rise, scl_fall, start_c, stop_c;
    logic [6:0]  dev_id;

    assign scl_rise = scl_now & ~scl_prev;
    assign scl_fall = ~scl_now & scl_prev;
    assign start_c  = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_c   = scl_now & scl_prev & ~sda_prev & sda_now;
    assign dev_id   = (DEV_BASE & HI_MASK) | (7'(strap_i) & ~HI_MASK);
    assign commit_o = stop_c & pend & ~busy_i;

    // Protocol sequencing: shift bytes on SCL rise, change SDA drive on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            txsh      <= '0;
            cnt       <= '0;
            pend      <= 1'b0;
            rd_mode   <= 1'b0;
            sda_low_o <= 1'b0;
            ptr_o     <= '0;
            wdata_o   <= '0;
        end else if (busy_i) begin
            state     <= ST_IDLE;
            sda_low_o <= 1'b0;
            pend      <= 1'b0;
            cnt       <= '0;
        end else if (stop_c) begin
            state     <= ST_IDLE;
            sda_low_o <= 1'b0;
            pend      <= 1'b0;
        end else if (start_c) begin
            state     <= ST_DEV;
            sda_low_o <= 1'b0;
            pend      <= 1'b0;
            cnt       <= '0;
        end else begin
            case (state)
                ST_DEV, ST_REG, ST_DAT: begin
                    if (scl_rise && cnt < 4'd8) begin
                        shreg <= {shreg[6:0], sda_now};
                        cnt   <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        cnt <= '0;
                        if (state == ST_DEV) begin
                            if (shreg[7:1] == dev_id) begin
                                rd_mode   <= shreg[0];
                                sda_low_o <= 1'b1;
                                state     <= ST_DEV_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_REG) begin
                            ptr_o     <= shreg;
                            sda_low_o <= 1'b1;
                            state     <= ST_REG_ACK;
                        end else begin
                            wdata_o   <= shreg;
                            pend      <= 1'b1;
                            sda_low_o <= 1'b1;
                            state     <= ST_DAT_ACK;
                        end
                    end
                end
                ST_DEV_ACK: if (scl_fall) begin
                    if (rd_mode) begin
                        txsh      <= rd_data_i;
                        sda_low_o <= ~rd_data_i[7];
                        state     <= ST_TX;
                    end else begin
                        sda_low_o <= 1'b0;
                        state     <= ST_REG;
                    end
                end
                ST_REG_ACK: if (scl_fall) begin
                    sda_low_o <= 1'b0;
                    state     <= ST_DAT;
                end
                ST_DAT_ACK: if (scl_fall) begin
                    sda_low_o <= 1'b0;
                    state     <= ST_HOLD;
                end
                ST_TX: if (scl_fall) begin
                    if (cnt == 4'd7) begin
                        sda_low_o <= 1'b0;
                        cnt       <= '0;
                        state     <= ST_TX_ACK;
                    end else begin
                        txsh      <= {txsh[6:0], 1'b0};
                        sda_low_o <= ~txsh[6];
                        cnt       <= cnt + 4'd1;
                    end
                end
                ST_TX_ACK: if (scl_fall) state <= ST_HOLD;
                default: ;
            endcase
        end
    end

    AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !sda_low_o); // R7
    AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> !$past(scl_now)); // R3
    AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (state == ST_IDLE) && !sda_low_o); // R5
endmodule

// File: rtl/trim_bank.sv
// Trimmer register bank with commit timer. A commit stores the data when the pointer
// is in range and always starts the busy window. Assumes commit_i is never raised while busy.
module trim_bank #(
    parameter int         N_REG     = 3,
    parameter logic [7:0] REG_BASE  = 8'hF8,
    parameter int         WR_CYCLES = 1000,
    parameter logic [7:0] RST_VAL   = 8'h7F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic [7:0]         ptr_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rd_data_o,
    output logic               busy_o,
    output logic [N_REG*7-1:0] pos_o,
    output logic [N_REG-1:0]   hiz_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [7:0]    regs [N_REG];
    logic [CW-1:0] tmr;

    for (genvar gi = 0; gi < N_REG; gi++) begin : g_reg
        // Hold one register; load it on a commit addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[gi] <= RST_VAL;
            else if (commit_i && ptr_i == 8'(REG_BASE + gi))
                regs[gi] <= wdata_i;
        end
        assign pos_o[gi*7 +: 7] = regs[gi][6:0];
        assign hiz_o[gi]        = regs[gi][7];

        AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !commit_i |=> $stable(regs[gi])); // R5
    end

    // Select read data; unmapped addresses read as all ones.
    always_comb begin
        rd_data_o = 8'hFF;
        for (int i = 0; i < N_REG; i++)
            if (ptr_i == 8'(REG_BASE + i)) rd_data_o = regs[i];
    end

    // Count down the commit window.
    always_ff @(posedge clk) begin
        if (!rst_n)         tmr <= '0;
        else if (commit_i)  tmr <= CW'(WR_CYCLES);
        else if (tmr != '0) tmr <= tmr - 1'b1;
    end
    assign busy_o = (tmr != '0);

    AST_COMMIT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !busy_o); // R7
    AST_COMMIT_STARTS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> busy_o); // R7
endmodule

// File: rtl/trim_serial_slave.sv
// Top level: two-wire slave in front of N_REG trimmer registers.
// Assumes SCL and SDA are asynchronous and idle high. The open-drain data output is given as a drive-low enable.
module trim_serial_slave #(
    parameter int         N_REG     = 3,
    parameter logic [7:0] REG_BASE  = 8'hF8,
    parameter int         WR_CYCLES = 1000,
    parameter logic [6:0] DEV_BASE  = 7'h50,
    parameter int         STRAP_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic               busy_o,
    output logic [N_REG*7-1:0] pos_o,
    output logic [N_REG-1:0]   hiz_o
);
    logic [1:0] now_s, prev_s;
    logic       commit;
    logic [7:0] ptr, wdata, rd_data;

    tw_sync #(.W(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
        .now_o(now_s), .prev_o(prev_s)
    );

    tw_link #(.DEV_BASE(DEV_BASE), .STRAP_W(STRAP_W)) i_link (
        .clk(clk), .rst_n(rst_n),
        .scl_now(now_s[1]), .scl_prev(prev_s[1]),
        .sda_now(now_s[0]), .sda_prev(prev_s[0]),
        .strap_i(strap_i), .busy_i(busy_o), .rd_data_i(rd_data),
        .sda_low_o(sda_pull_o), .commit_o(commit),
        .ptr_o(ptr), .wdata_o(wdata)
    );

    trim_bank #(.N_REG(N_REG), .REG_BASE(REG_BASE), .WR_CYCLES(WR_CYCLES)) i_bank (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .ptr_i(ptr),
        .wdata_i(wdata), .rd_data_o(rd_data), .busy_o(busy_o),
        .pos_o(pos_o), .hiz_o(hiz_o)
    );
endmodule

// File: tb/test_trim_serial_slave.sv
module test_trim_serial_slave;
    localparam int N_REG = 3;
    localparam int WRC   = 200;
    localparam int Q     = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [0:0] strap = 1'b1;
    logic sda_pull, busy;
    logic [N_REG*7-1:0] pos;
    logic [N_REG-1:0] hiz;
    wire  sda_line = sda_m & ~sda_pull;

    int checks = 0, fails = 0, busy_cnt = 0;
    bit done = 1'b0;
    logic [7:0] model [N_REG];

    always #10 clk = ~clk;

    trim_serial_slave #(.N_REG(N_REG), .WR_CYCLES(WRC)) i_trim_serial_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
        .sda_pull_o(sda_pull), .busy_o(busy), .pos_o(pos), .hiz_o(hiz)
    );

    always @(negedge clk) if (busy) busy_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0; wq();
        end
        wq(); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq();
    endtask

    task automatic check_outs(input string req);
        for (int i = 0; i < N_REG; i++) begin
            check(req, pos[i*7 +: 7], model[i][6:0]);
            check(req, hiz[i], model[i][7]);
        end
    endtask

    task automatic write_reg(input logic [7:0] rg, input logic [7:0] dat, input string req);
        logic a0, a1, a2;
        int b0;
        bus_start;
        send_byte(8'hA2, a0); send_byte(rg, a1); send_byte(dat, a2);
        check({req, " R3 acks"}, {a0, a1, a2}, 3'b111);
        check_outs({req, " R5 before stop"});
        b0 = busy_cnt;
        bus_stop;
        if (rg >= 8'hF8 && rg < 8'hF8 + N_REG) model[rg - 8'hF8] = dat;
        while (busy) @(negedge clk);
        check({req, " R7 busy length"}, busy_cnt - b0, WRC);
        check_outs({req, " R5 R6 after stop"});
    endtask

    task automatic read_reg(input logic [7:0] rg, output logic [7:0] val, output logic ok);
        logic a0, a1, a2;
        bus_start; send_byte(8'hA2, a0); send_byte(rg, a1);
        bus_start; send_byte(8'hA3, a2);
        recv_byte(val);
        bus_stop;
        ok = a0 & a1 & a2;
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] rg);
        if (rg >= 8'hF8 && rg < 8'hF8 + N_REG) return model[rg - 8'hF8];
        return 8'hFF;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a, ok;
        logic [7:0] v, rg, dat;
        int b0;
        void'($urandom(32'd2024));
        for (int i = 0; i < N_REG; i++) model[i] = 8'h7F;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wq();
        // R4 reset state
        check_outs("R4 reset");
        check("R4 busy", busy, 1'b0);
        check("R4 sda", sda_pull, 1'b0);

        // R1 wrong address: no ack, rest ignored
        bus_start; send_byte(8'hA0, a);
        check("R1 mismatch ack", a, 1'b0);
        send_byte(8'hF9, a);
        check("R1 ignored ack", a, 1'b0);
        b0 = busy_cnt; bus_stop; wq(4);
        check("R1 no commit", busy_cnt - b0, 0);
        check_outs("R1 regs");

        // R2 R5 write with stop
        write_reg(8'hF8, 8'h15, "R2 R5 write F8");

        // R7 address during busy not acked
        bus_start; send_byte(8'hA2, a); send_byte(8'hF9, a); send_byte(8'h33, a);
        bus_stop;
        b0 = busy_cnt;
        bus_start; send_byte(8'hA2, a);
        check("R7 ack while busy", a, 1'b0);
        bus_stop;
        model[1] = 8'h33;
        while (busy) @(negedge clk);
        check_outs("R7 polled write");

        // R6 high impedance and minimum
        write_reg(8'hFA, 8'h80, "R6 hiz");
        write_reg(8'hF9, 8'h00, "R6 min");
        write_reg(8'hF9, 8'hC5, "R6 above max");

        // R8 read back
        read_reg(8'hF8, v, ok);
        check("R8 read ack", ok, 1'b1);
        check("R8 read F8", v, 8'h15);
        read_reg(8'hFA, v, ok);
        check("R8 read FA", v, 8'h80);

        // R9 out of range
        write_reg(8'hFB, 8'h12, "R9 write FB");
        read_reg(8'hFB, v, ok);
        check("R9 read FB", v, 8'hFF);

        // R5 aborted by repeated start
        bus_start; send_byte(8'hA2, a); send_byte(8'hF8, a); send_byte(8'h6A, a);
        b0 = busy_cnt;
        bus_start; bus_stop; wq(4);
        check("R5 abort no busy", busy_cnt - b0, 0);
        check_outs("R5 abort regs");

        // random mix
        for (int k = 0; k < 14; k++) begin
            rg  = 8'hF8 + 8'($urandom_range(0, 3));
            dat = 8'($urandom);
            write_reg(rg, dat, "R5 R6 random");
            read_reg(rg, v, ok);
            check("R8 R9 random read", v, exp_read(rg));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule